// File: doc/BRIEF.md
# UART Baud Clock Source Selector

This block decides where a UART's bit-rate ticks come from. A single byte-wide control register selects, separately for transmit and for receive, either an on-block baud generator or an externally supplied timer tick. The on-block generator is a reload counter. It counts peripheral-clock enable pulses, and in its slow setting a divide-by-6 prescaler sits in front of it. Software can start and stop it.

The block also produces the shift tick for the UART's synchronous mode 0. That tick comes either from the on-block generator or from a fixed divider. The divider divides the peripheral clock by 12, or by 6 when the double-speed (X2) input is high. All counting advances only on cycles where the clock-enable input is high. The UART shift logic that consumes the ticks lies outside this block.

Top module: `baud_clk_sel`

## Requirements
- R1: A write stores `wr_data[4:0]` in the control register and `rd_data[4:0]` returns it from the next cycle on. The field positions are: bit 4 = run, bit 3 = transmit uses internal generator, bit 2 = receive uses internal generator, bit 1 = fast rate, bit 0 = mode-0 uses internal generator.
- R2: Bits 7..5 of a write are ignored, and `rd_data[7:5]` always reads 0.
- R3: After reset `rd_data` is 0x00, and both `tx_tick` and `rx_tick` follow `tmr_tick`.
- R4: While the run bit is 0, the internal generator emits no tick and its count is held. After the run bit is set again, counting resumes from the held value.
- R5: With bit 3 set, `tx_tick` is the internal generator tick. With bit 3 clear, `tx_tick` is `tmr_tick`.
- R6: Bit 2 selects the source of `rx_tick` in the same way, independently of bit 3.
- R7: In fast mode (bit 1 = 1), the internal tick repeats every 2^CNT_W − `reload` enabled cycles (10 for reload 246 with CNT_W = 8).
- R8: In slow mode (bit 1 = 0), the internal tick period is PRESCALE (6) times the fast period.
- R9: With bit 0 clear, `m0_tick` repeats every 12 enabled cycles when `x2_mode` is 0, and every 6 when it is 1. Each tick lasts one cycle.
- R10: With bit 0 set, `m0_tick` is the internal generator tick.
- R11: The prescaler, the generator and the mode-0 divider advance only in cycles where `clk_en` is 1, and no tick is raised unless `clk_en` was 1 in the cycle before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clk_en | input | 1 | Peripheral clock enable; one enabled cycle is one count |
| x2_mode | input | 1 | Double-speed mode for the mode-0 fallback divider |
| wr_en | input | 1 | Control register write strobe |
| wr_data | input | 8 | Control register write data |
| rd_data | output | 8 | Control register read data |
| reload | input | CNT_W | Reload value of the internal generator |
| tmr_tick | input | 1 | External timer baud tick |
| tx_tick | output | 1 | Transmit baud tick |
| rx_tick | output | 1 | Receive baud tick |
| m0_tick | output | 1 | Mode-0 shift tick |

## Verification
The generator is measured as a tick-to-tick interval. It is tried at two reload values in fast mode, at one in slow mode, and with the enable gated to every other cycle. These patterns separate reload arithmetic errors, a missing or wrong prescaler, and counting that ignores the enable. The transmit and receive selects are driven to opposite settings while the external tick is held high and the generator is stopped, which shows whether either path is tied to the other's select bit. The mode-0 path is measured with the divider at both X2 settings and with the generator at a reload whose period is neither 6 nor 12, so that no source can be mistaken for another. A stop of known length in the middle of a period shows whether the count is held or restarted.

// File: rtl/baud_sel_pkg.sv
package baud_sel_pkg;

  localparam int REG_W = 8;
  localparam int CTL_W = 5;

  // Control fields, MSB first: bit 4 run ... bit 0 mode-0 source
  typedef struct packed {
    logic run;
    logic tx_int;
    logic rx_int;
    logic fast;
    logic m0_int;
  } ctl_t;

  function automatic ctl_t byte_to_ctl(input logic [CTL_W-1:0] b);
    return ctl_t'(b);
  endfunction

  function automatic logic [REG_W-1:0] ctl_to_byte(input ctl_t c);
    return {{(REG_W-CTL_W){1'b0}}, c};
  endfunction

  // Last count value of the mode-0 fallback divider
  function automatic int unsigned div_last(input logic x2, input int unsigned d,
                                           input int unsigned dx2);
    return (x2 ? dx2 : d) - 1;
  endfunction

endpackage

// File: rtl/baud_ctl_reg.sv
module baud_ctl_reg
  import baud_sel_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [CTL_W-1:0] wr_ctl,
  output ctl_t             ctl,
  output logic [REG_W-1:0] rd_data
);

  ctl_t ctl_q;

  always_ff @(posedge clk) begin
    if (!rst_n)
      ctl_q <= '0;
    else if (wr_en)
      ctl_q <= byte_to_ctl(wr_ctl);
  end

  assign ctl     = ctl_q;
  assign rd_data = ctl_to_byte(ctl_q);

endmodule

// File: rtl/baud_int_gen.sv
module baud_int_gen #(
  parameter int CNT_W    = 8,
  parameter int PRESCALE = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clk_en,
  input  logic             run,
  input  logic             fast,
  input  logic [CNT_W-1:0] reload,
  output logic             gen_tick,
  output logic [CNT_W-1:0] cnt_o
);

  localparam int PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam logic [PW-1:0]    PRE_LAST = PW'(PRESCALE - 1);
  localparam logic [CNT_W-1:0] CNT_MAX  = '1;

  logic [PW-1:0]    pre_q;
  logic [CNT_W-1:0] cnt_q;
  logic             tick_q;
  logic             pre_wrap;
  logic             step;
  logic             at_max;

  assign pre_wrap = (pre_q == PRE_LAST);
  assign step     = run && clk_en && (fast || pre_wrap);
  assign at_max   = (cnt_q == CNT_MAX);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pre_q  <= '0;
      cnt_q  <= '0;
      tick_q <= 1'b0;
    end else begin
      if (run && clk_en && !fast)
        pre_q <= pre_wrap ? '0 : pre_q + 1'b1;
      if (step)
        cnt_q <= at_max ? reload : cnt_q + 1'b1;
      tick_q <= step && at_max;
    end
  end

  assign gen_tick = tick_q;
  assign cnt_o    = cnt_q;

endmodule

// File: rtl/baud_m0_div.sv
module baud_m0_div
  import baud_sel_pkg::*;
#(
  parameter int M0_DIV    = 12,
  parameter int M0_DIV_X2 = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clk_en,
  input  logic x2_mode,
  output logic div_tick
);

  localparam int CW = $clog2(M0_DIV);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] last;
  logic          tick_q;
  logic          wrap;

  assign last = CW'(div_last(x2_mode, M0_DIV, M0_DIV_X2));
  assign wrap = (cnt_q >= last);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      tick_q <= 1'b0;
    end else begin
      if (clk_en)
        cnt_q <= wrap ? '0 : cnt_q + 1'b1;
      tick_q <= clk_en && wrap;
    end
  end

  assign div_tick = tick_q;

endmodule

// File: rtl/baud_clk_sel.sv
module baud_clk_sel
  import baud_sel_pkg::*;
#(
  parameter int CNT_W     = 8,
  parameter int PRESCALE  = 6,
  parameter int M0_DIV    = 12,
  parameter int M0_DIV_X2 = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clk_en,
  input  logic             x2_mode,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data,
  input  logic [CNT_W-1:0] reload,
  input  logic             tmr_tick,
  output logic             tx_tick,
  output logic             rx_tick,
  output logic             m0_tick
);

  ctl_t             ctl_q;
  logic             gen_tick;
  logic [CNT_W-1:0] gen_cnt;
  logic             div_tick;

  baud_ctl_reg u_reg (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_ctl  (wr_data[CTL_W-1:0]),
    .ctl     (ctl_q),
    .rd_data (rd_data)
  );

  baud_int_gen #(.CNT_W(CNT_W), .PRESCALE(PRESCALE)) u_gen (
    .clk      (clk),
    .rst_n    (rst_n),
    .clk_en   (clk_en),
    .run      (ctl_q.run),
    .fast     (ctl_q.fast),
    .reload   (reload),
    .gen_tick (gen_tick),
    .cnt_o    (gen_cnt)
  );

  baud_m0_div #(.M0_DIV(M0_DIV), .M0_DIV_X2(M0_DIV_X2)) u_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .clk_en   (clk_en),
    .x2_mode  (x2_mode),
    .div_tick (div_tick)
  );

  assign tx_tick = ctl_q.tx_int ? gen_tick : tmr_tick;
  assign rx_tick = ctl_q.rx_int ? gen_tick : tmr_tick;
  assign m0_tick = ctl_q.m0_int ? gen_tick : div_tick;

endmodule

// File: rtl/baud_clk_sel_chk.sv
module baud_clk_sel_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             clk_en,
  input logic             wr_en,
  input logic [7:0]       wr_data,
  input logic [7:0]       rd_data,
  input logic             run,
  input logic             gen_tick,
  input logic [CNT_W-1:0] gen_cnt,
  input logic             div_tick
);

  // R1
  wr_back_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> rd_data[4:0] == $past(wr_data[4:0]));

  // R2
  rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[7:5] != 3'b000) |=> rd_data[7:5] == 3'b000);

  // R4
  stop_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gen_tick |-> $past(run));

  // R4
  stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> $stable(gen_cnt));

  // R11
  gen_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gen_tick |-> $past(clk_en));

  // R11
  div_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    div_tick |-> $past(clk_en));

  // R9
  div_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    div_tick |=> !div_tick);

endmodule

bind baud_clk_sel baud_clk_sel_chk #(.CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .clk_en   (clk_en),
  .wr_en    (wr_en),
  .wr_data  (wr_data),
  .rd_data  (rd_data),
  .run      (ctl_q.run),
  .gen_tick (gen_tick),
  .gen_cnt  (gen_cnt),
  .div_tick (div_tick)
);

// File: tb/baud_clk_sel_test.sv
`timescale 1ns/1ps
module baud_clk_sel_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       clk_en = 1'b1;
  logic       gate = 1'b0;
  logic       x2_mode = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic [7:0] reload = 8'd246;
  logic       tmr_tick = 1'b0;
  logic       tx_tick, rx_tick, m0_tick;

  int checks = 0;
  int fails  = 0;
  int ncyc   = 0;

  always #10 clk = ~clk;
  always @(posedge clk) ncyc <= ncyc + 1;
  always @(negedge clk) clk_en <= gate ? ~clk_en : 1'b1;

  baud_clk_sel uut (
    .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .x2_mode(x2_mode),
    .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data), .reload(reload),
    .tmr_tick(tmr_tick), .tx_tick(tx_tick), .rx_tick(rx_tick), .m0_tick(m0_tick)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1;
    wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  function automatic logic sig(input int sel);
    case (sel)
      0: return tx_tick;
      1: return rx_tick;
      default: return m0_tick;
    endcase
  endfunction

  task automatic next_tick(input int sel, output int at);
    at = -1;
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (sig(sel)) begin
        at = ncyc;
        break;
      end
    end
  endtask

  task automatic gap_of(input int sel, output int gap);
    int a, b;
    next_tick(sel, a);
    next_tick(sel, a);
    next_tick(sel, b);
    gap = (a < 0 || b < 0) ? -1 : b - a;
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(rd_data == 8'h00, "R3 reset value", rd_data, 0);
    tmr_tick = 1'b1;
    #1;
    check(tx_tick == 1'b1, "R3 tx from timer", tx_tick, 1);
    check(rx_tick == 1'b1, "R3 rx from timer", rx_tick, 1);
    tmr_tick = 1'b0;
  endtask

  task automatic t_reg();
    wr(8'h15);
    check(rd_data == 8'h15, "R1 readback 15", rd_data, 8'h15);
    wr(8'h0A);
    check(rd_data == 8'h0A, "R1 readback 0A", rd_data, 8'h0A);
    wr(8'hFF);
    check(rd_data == 8'h1F, "R2 reserved masked", rd_data, 8'h1F);
    wr(8'hE0);
    check(rd_data == 8'h00, "R2 reserved only", rd_data, 0);
  endtask

  task automatic t_sel();
    wr(8'h08);
    tmr_tick = 1'b1;
    repeat (3) @(negedge clk);
    check(tx_tick == 1'b0, "R5 tx internal stopped", tx_tick, 0);
    check(rx_tick == 1'b1, "R6 rx timer", rx_tick, 1);
    wr(8'h04);
    check(tx_tick == 1'b1, "R5 tx timer", tx_tick, 1);
    check(rx_tick == 1'b0, "R6 rx internal stopped", rx_tick, 0);
    tmr_tick = 1'b0;
  endtask

  task automatic t_fast();
    int g;
    reload = 8'd246;
    wr(8'h1E);
    gap_of(0, g);
    check(g == 10, "R7 fast tx period 246", g, 10);
    gap_of(1, g);
    check(g == 10, "R6 rx internal period", g, 10);
    reload = 8'd200;
    gap_of(0, g);
    check(g == 56, "R7 fast period 200", g, 56);
  endtask

  task automatic t_slow();
    int g;
    reload = 8'd246;
    wr(8'h1C);
    gap_of(0, g);
    check(g == 60, "R8 slow period", g, 60);
  endtask

  task automatic t_hold();
    int a, b;
    bit quiet;
    quiet = 1'b1;
    reload = 8'd246;
    wr(8'h1A);
    next_tick(0, a);
    next_tick(0, a);
    wr(8'h0A);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (tx_tick) quiet = 1'b0;
    end
    check(quiet, "R4 no tick while stopped", int'(quiet), 1);
    wr(8'h1A);
    next_tick(0, b);
    check(b - a == 32, "R4 count held across stop", b - a, 32);
  endtask

  task automatic t_m0();
    int g;
    wr(8'h00);
    x2_mode = 1'b0;
    gap_of(2, g);
    check(g == 12, "R9 divide by 12", g, 12);
    x2_mode = 1'b1;
    gap_of(2, g);
    check(g == 6, "R9 divide by 6 in x2", g, 6);
    x2_mode = 1'b0;
    gate = 1'b1;
    gap_of(2, g);
    check(g == 24, "R11 divider counts enabled cycles", g, 24);
    gate = 1'b0;
    reload = 8'd246;
    wr(8'h13);
    gap_of(2, g);
    check(g == 10, "R10 mode 0 from generator", g, 10);
  endtask

  task automatic t_gated_gen();
    int g;
    reload = 8'd246;
    wr(8'h1A);
    gate = 1'b1;
    gap_of(0, g);
    check(g == 20, "R11 generator counts enabled cycles", g, 20);
    gate = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_reg();
    t_sel();
    t_fast();
    t_slow();
    t_hold();
    t_m0();
    t_gated_gen();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule